// File: doc/BRIEF.md
# Key-Guarded Configuration Register with On-Chip Auxiliary Data RAM

This block holds one protected configuration byte and a 256-byte auxiliary RAM for a small processor subsystem. Software can change the configuration byte only after it opens a two-byte key sequence on a separate key register. Once the configuration is set, a key write of zero closes the guard again. Reads of the configuration byte always work, whether the guard is open or not.

The block also sits on the processor's external-data path and steers each access. One configuration bit turns on the auxiliary RAM. While that bit is set, every access made through an 8-bit pointer is served from the on-chip RAM, and the external bus stays completely quiet. Accesses made through a 16-bit pointer always go to the external bus with their full address. When the RAM is off, 8-bit pointer accesses also go to the external bus, with the upper address byte forced to zero.

Each request is one cycle long. Its bus strobe, or its on-chip read data, appears one cycle after the request.

Top module: `cfg_lock_auxram`

## Requirements
- R1: After reset the configuration byte reads 00h, the auxiliary RAM is off, the guard is closed, and every external bus output is 0.
- R2: Writing 87h and then 59h to the key register opens the guard. While the guard is open, a configuration write takes effect at the next clock edge.
- R3: While the guard is opening, any key byte other than the expected next one returns it to closed. For example, 87h,11h,59h does not open the guard, and neither does 87h,87h,59h.
- R4: While the guard is open, writing 00h to the key register closes it. Any other key byte leaves it open.
- R5: While the guard is closed, or only half open, configuration writes are ignored. A read of the configuration address always returns the current value. A read of any other address returns 00h.
- R6: Configuration bits 6 and 5 are not implemented and always read 0. Bits 7 and 4..0 store what is written.
- R7: Configuration bit 4 enables the auxiliary RAM. With it set, an 8-bit-pointer write stores the byte at the low 8 address bits. An 8-bit-pointer read returns that byte on the read-data output, with read-valid high, one cycle after the request.
- R8: An access served by the auxiliary RAM asserts neither bus strobe, and leaves the bus address and bus write data at 0.
- R9: A 16-bit-pointer access always goes to the external bus with its full 16-bit address, whatever bit 4 says. The read or write strobe is high for exactly the one cycle after the request.
- R10: With bit 4 clear, an 8-bit-pointer access goes to the external bus at address {00h, low byte}.
- R11: During an external read strobe cycle, read-valid is high and the read-data output carries the external read-data input.
- R12: The two bus strobes are never high together. When neither strobe is high, the bus address and bus write data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register port address |
| regWrData | input | 8 | Register write data |
| regWrEn | input | 1 | Register write strobe |
| regRdData | output | 8 | Register read data (combinational) |
| xReq | input | 1 | External-data access request, one cycle |
| xShort | input | 1 | 1 = the access uses an 8-bit pointer, 0 = a 16-bit pointer |
| xWrite | input | 1 | 1 = write, 0 = read |
| xAddr | input | 16 | Access address |
| xWrData | input | 8 | Access write data |
| xRdData | output | 8 | Access read data |
| xRdValid | output | 1 | Read data valid, one cycle after a read request |
| extAddr | output | 16 | External bus address |
| extWrData | output | 8 | External bus write data |
| extRdStb | output | 1 | External read strobe, active high |
| extWrStb | output | 1 | External write strobe, active high |
| extRdData | input | 8 | External bus read data |

## Verification
Assertions check, on every cycle, properties that hold across all traffic:
- the configuration byte moves only while the guard is open;
- the guard opens only from its half-open state;
- the unimplemented bits read zero;
- an on-chip access leaves the bus silent;
- the strobes are exclusive and an idle bus is zero;
- 8-bit-pointer bus accesses carry a zero upper address byte.

Only the bench's scenarios can show the key-sequence outcomes: the broken sequences, closing with 00h, and staying open on other bytes. The scenarios also show that a byte written to the auxiliary RAM comes back on a later read, and that 16-bit and 8-bit pointers are routed correctly with the RAM both off and on.

// File: rtl/cfgram_pkg.sv
package cfgram_pkg;

  typedef enum logic [1:0] {
    GUARD_SHUT = 2'd0,
    GUARD_HALF = 2'd1,
    GUARD_OPEN = 2'd2
  } guardT;

  // steering strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic ramWr;
    logic ramRd;
    logic extWr;
    logic extRd;
  } steerT;

  localparam logic [7:0] KEY_FIRST     = 8'h87;
  localparam logic [7:0] KEY_SECOND    = 8'h59;
  localparam logic [7:0] KEY_SHUT      = 8'h00;
  localparam logic [7:0] CFG_IMPL_MASK = 8'b1001_1111;
  localparam int         AUX_EN_BIT    = 4;

endpackage

// File: rtl/cfgram_ctrl.sv
module cfgram_ctrl
  import cfgram_pkg::*;
#(
  parameter int              REG_AW   = 8,
  parameter logic [REG_AW-1:0] KEY_ADDR = 8'h30,
  parameter logic [REG_AW-1:0] CFG_ADDR = 8'h31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              regWrEn,
  output logic [7:0]        regRdData,
  input  logic              xReq,
  input  logic              xShort,
  input  logic              xWrite,
  output steerT             steer
);

  guardT      guardQ, guardD;
  logic [7:0] cfgQ;
  logic       keyWr, cfgWr, auxEn, onChip;

  assign keyWr = regWrEn && (regAddr == KEY_ADDR);
  assign cfgWr = regWrEn && (regAddr == CFG_ADDR);

  // key sequence tracking
  always_comb begin
    guardD = guardQ;
    if (keyWr) begin
      unique case (guardQ)
        GUARD_SHUT: guardD = (regWrData == KEY_FIRST)  ? GUARD_HALF : GUARD_SHUT;
        GUARD_HALF: guardD = (regWrData == KEY_SECOND) ? GUARD_OPEN : GUARD_SHUT;
        GUARD_OPEN: guardD = (regWrData == KEY_SHUT)   ? GUARD_SHUT : GUARD_OPEN;
        default:    guardD = GUARD_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      guardQ <= GUARD_SHUT;
      cfgQ   <= 8'h00;
    end else begin
      guardQ <= guardD;
      if (cfgWr && guardQ == GUARD_OPEN)
        cfgQ <= regWrData & CFG_IMPL_MASK;
    end
  end

  assign regRdData = (regAddr == CFG_ADDR) ? (cfgQ & CFG_IMPL_MASK) : 8'h00;

  // access steering
  assign auxEn  = cfgQ[AUX_EN_BIT];
  assign onChip = xShort && auxEn;

  always_comb begin
    steer       = '0;
    steer.ramWr = xReq && onChip && xWrite;
    steer.ramRd = xReq && onChip && !xWrite;
    steer.extWr = xReq && !onChip && xWrite;
    steer.extRd = xReq && !onChip && !xWrite;
  end

  // R5: the config byte moves only while the guard was open
  assert_cfg_guard_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgQ) |-> $past(guardQ) == GUARD_OPEN);

  // R2: the open state is entered only from the half-open state
  assert_open_path_R2: assert property (@(posedge clk) disable iff (!rstN)
    (guardQ == GUARD_OPEN && $past(guardQ) != GUARD_OPEN) |-> $past(guardQ) == GUARD_HALF);

  // R6: unimplemented bits never read as 1
  assert_unimpl_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~CFG_IMPL_MASK) == 8'h00);

  // R8/R9: at most one steering target per cycle
  assert_steer_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(steer));

endmodule

// File: rtl/cfgram_dp.sv
module cfgram_dp
  import cfgram_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int PTR_W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  steerT         steer,
  input  logic [AW-1:0] xAddr,
  input  logic          xShort,
  input  logic [DW-1:0] xWrData,
  output logic [DW-1:0] xRdData,
  output logic          xRdValid,
  output logic [AW-1:0] extAddr,
  output logic [DW-1:0] extWrData,
  output logic          extRdStb,
  output logic          extWrStb,
  input  logic [DW-1:0] extRdData
);

  localparam int DEPTH = 1 << PTR_W;
  localparam int HI_W  = AW - PTR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ramQ;
  logic          ramRdQ, extRdQ, extWrQ;
  logic [AW-1:0] busAddrQ, busAddrD;
  logic [DW-1:0] busDataQ;
  logic [PTR_W-1:0] ramIdx;

  assign ramIdx   = xAddr[PTR_W-1:0];
  assign busAddrD = xShort ? {{HI_W{1'b0}}, xAddr[PTR_W-1:0]} : xAddr;

  // auxiliary storage, no reset on contents
  always_ff @(posedge clk) begin
    if (steer.ramWr)
      mem[ramIdx] <= xWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramQ     <= '0;
      ramRdQ   <= 1'b0;
      extRdQ   <= 1'b0;
      extWrQ   <= 1'b0;
      busAddrQ <= '0;
      busDataQ <= '0;
    end else begin
      ramRdQ <= steer.ramRd;
      extRdQ <= steer.extRd;
      extWrQ <= steer.extWr;
      if (steer.ramRd)
        ramQ <= mem[ramIdx];
      if (steer.extRd || steer.extWr) begin
        busAddrQ <= busAddrD;
        busDataQ <= steer.extWr ? xWrData : '0;
      end else begin
        busAddrQ <= '0;
        busDataQ <= '0;
      end
    end
  end

  assign extRdStb  = extRdQ;
  assign extWrStb  = extWrQ;
  assign extAddr   = busAddrQ;
  assign extWrData = busDataQ;
  assign xRdValid  = ramRdQ || extRdQ;
  assign xRdData   = ramRdQ ? ramQ : (extRdQ ? extRdData : '0);

  // R8: on-chip access keeps the bus silent in the following cycle
  assert_onchip_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (steer.ramRd || steer.ramWr) |=> (!extRdStb && !extWrStb && extAddr == '0));

  // R12: strobes exclusive
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(extRdStb && extWrStb));

  // R12: idle bus is zero
  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(extRdStb || extWrStb) |-> (extAddr == '0 && extWrData == '0));

  // R10: short-pointer bus access carries a zero upper byte
  assert_short_upper_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((steer.extRd || steer.extWr) && xShort) |=> extAddr[AW-1:PTR_W] == '0);

  // R9: a bus strobe lasts one cycle per request
  assert_strobe_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    (extRdStb || extWrStb) |-> $past(steer.extRd || steer.extWr));

endmodule

// File: rtl/cfg_lock_auxram.sv
module cfg_lock_auxram
  import cfgram_pkg::*;
#(
  parameter int                REG_AW   = 8,
  parameter logic [REG_AW-1:0] KEY_ADDR = 8'h30,
  parameter logic [REG_AW-1:0] CFG_ADDR = 8'h31,
  parameter int                AW       = 16,
  parameter int                DW       = 8,
  parameter int                PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              regWrEn,
  output logic [7:0]        regRdData,
  input  logic              xReq,
  input  logic              xShort,
  input  logic              xWrite,
  input  logic [AW-1:0]     xAddr,
  input  logic [DW-1:0]     xWrData,
  output logic [DW-1:0]     xRdData,
  output logic              xRdValid,
  output logic [AW-1:0]     extAddr,
  output logic [DW-1:0]     extWrData,
  output logic              extRdStb,
  output logic              extWrStb,
  input  logic [DW-1:0]     extRdData
);

  steerT steer;

  cfgram_ctrl #(
    .REG_AW(REG_AW), .KEY_ADDR(KEY_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData),
    .xReq(xReq), .xShort(xShort), .xWrite(xWrite),
    .steer(steer)
  );

  cfgram_dp #(
    .AW(AW), .DW(DW), .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .steer(steer),
    .xAddr(xAddr), .xShort(xShort), .xWrData(xWrData),
    .xRdData(xRdData), .xRdValid(xRdValid),
    .extAddr(extAddr), .extWrData(extWrData),
    .extRdStb(extRdStb), .extWrStb(extWrStb), .extRdData(extRdData)
  );

endmodule

// File: tb/cfg_lock_auxram_tb.sv
module cfg_lock_auxram_tb;

  localparam logic [7:0] KEY_A = 8'h30;
  localparam logic [7:0] CFG_A = 8'h31;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0, regWrData = '0, regRdData;
  logic        regWrEn = 1'b0;
  logic        xReq = 1'b0, xShort = 1'b0, xWrite = 1'b0;
  logic [15:0] xAddr = '0;
  logic [7:0]  xWrData = '0, xRdData;
  logic        xRdValid;
  logic [15:0] extAddr;
  logic [7:0]  extWrData, extRdData = '0;
  logic        extRdStb, extWrStb;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_lock_auxram u_dut (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn), .regRdData(regRdData),
    .xReq(xReq), .xShort(xShort), .xWrite(xWrite), .xAddr(xAddr), .xWrData(xWrData),
    .xRdData(xRdData), .xRdValid(xRdValid),
    .extAddr(extAddr), .extWrData(extWrData), .extRdStb(extRdStb), .extWrStb(extWrStb),
    .extRdData(extRdData)
  );

  // {isCfg, data, expected config read afterwards}
  localparam int NV = 22;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'hFF, 8'h00},  // R5 shut: ignored
    {1'b0, 8'h87, 8'h00},
    {1'b1, 8'hFF, 8'h00},  // R5 half open: ignored
    {1'b0, 8'h59, 8'h00},  // R2 now open
    {1'b1, 8'hFF, 8'h9F},  // R2 R6 write lands, bits 6,5 zero
    {1'b1, 8'h00, 8'h00},  // R2 still open
    {1'b0, 8'h00, 8'h00},  // R4 shut
    {1'b1, 8'hFF, 8'h00},  // R4 R5 ignored after shut
    {1'b0, 8'h87, 8'h00},
    {1'b0, 8'h11, 8'h00},  // R3 wrong byte
    {1'b0, 8'h59, 8'h00},
    {1'b1, 8'h10, 8'h00},  // R3 not open
    {1'b0, 8'h87, 8'h00},
    {1'b0, 8'h87, 8'h00},  // R3 repeated first key
    {1'b0, 8'h59, 8'h00},
    {1'b1, 8'h10, 8'h00},  // R3 not open
    {1'b0, 8'h87, 8'h00},
    {1'b0, 8'h59, 8'h00},
    {1'b0, 8'h42, 8'h00},  // R4 non-zero byte keeps open
    {1'b1, 8'h10, 8'h10},  // R4 write lands, aux on
    {1'b0, 8'h00, 8'h10},
    {1'b1, 8'h00, 8'h10}   // R5 ignored, value kept
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic isCfg, input logic [7:0] d);
    @(negedge clk);
    regAddr = isCfg ? CFG_A : KEY_A;
    regWrData = d;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    regAddr = CFG_A;
    #1;
  endtask

  // issue one request; returns at the negedge after the capturing edge
  task automatic access(input logic sh, input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    xReq = 1'b1; xShort = sh; xWrite = wr; xAddr = a; xWrData = d;
    @(negedge clk);
    xReq = 1'b0; xWrite = 1'b0; xAddr = '0; xWrData = '0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    regAddr = CFG_A;
    #1;
    // R1 reset state
    chk("R1 cfg after reset", regRdData, 8'h00);
    chk("R1 bus idle after reset", {extRdStb, extWrStb, xRdValid, extAddr}, 0);
    regAddr = KEY_A; #1;
    chk("R5 other address reads zero", regRdData, 8'h00);

    // R10 short pointer with aux off goes external, upper byte zero
    access(1'b1, 1'b1, 16'hAB34, 8'h5C);
    chk("R10 short write strobe", {extWrStb, extRdStb}, 2'b10);
    chk("R10 short write addr", extAddr, 16'h0034);
    chk("R10 short write data", extWrData, 8'h5C);
    @(negedge clk); #1;
    chk("R12 strobe one cycle", {extWrStb, extAddr, extWrData}, 0);

    // R9 R11 long read
    extRdData = 8'h5A;
    access(1'b0, 1'b0, 16'h1234, 8'h00);
    chk("R9 long read strobe/addr", {extRdStb, extWrStb, extAddr}, {2'b10, 16'h1234});
    chk("R11 read data via bus", {xRdValid, xRdData}, {1'b1, 8'h5A});

    // key/config table
    for (int i = 0; i < NV; i++) begin
      wrReg(VEC[i][16], VEC[i][15:8]);
      chk($sformatf("R2-table entry %0d cfg", i), regRdData, VEC[i][7:0]);
    end

    // aux now enabled: R7 R8
    access(1'b1, 1'b1, 16'h0012, 8'h34);
    chk("R8 on-chip write quiet", {extRdStb, extWrStb, extAddr, extWrData}, 0);
    access(1'b1, 1'b1, 16'hFFFF, 8'hC3);
    access(1'b1, 1'b0, 16'h0012, 8'h00);
    chk("R7 aux read 12h", {xRdValid, xRdData}, {1'b1, 8'h34});
    chk("R8 on-chip read quiet", {extRdStb, extWrStb, extAddr}, 0);
    access(1'b1, 1'b0, 16'h77FF, 8'h00);
    chk("R7 aux read FFh low byte index", {xRdValid, xRdData}, {1'b1, 8'hC3});

    // R9 long pointer still external with aux on
    extRdData = 8'hE1;
    access(1'b0, 1'b0, 16'h0012, 8'h00);
    chk("R9 long read external with aux on", {extRdStb, extAddr}, {1'b1, 16'h0012});
    chk("R11 long read data", xRdData, 8'hE1);
    access(1'b0, 1'b1, 16'hBEEF, 8'h99);
    chk("R9 long write external", {extWrStb, extAddr, extWrData}, {1'b1, 16'hBEEF, 8'h99});
    @(negedge clk); #1;
    chk("R12 idle after write", {extWrStb, extRdStb, xRdValid, extAddr, extWrData}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule